// File: doc/BRIEF.md
# UART FIFO Control and Receive Trigger

This block holds the write-only FIFO control register of a UART, together with the transmit and receive byte FIFOs that register governs and the receive-threshold interrupt. Software writes the register at offset 2 of the UART's 8-bit register bus. The write turns FIFO mode on or off, flushes either FIFO on request, picks the DMA signalling mode and selects one of four receive thresholds.

The serial side of the UART is outside this block. Its shifters load and unload the FIFOs through one-cycle push and pop strobes. The receive-data-available interrupt is a level that other logic combines into the UART's interrupt output. The DMA mode level is exported for the DMA handshake logic, which is not part of this block. A FIFO flush touches only the FIFO storage and counters, so a character already in a shifter is not disturbed.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset, FIFO mode is off, DMA mode 0 is selected, both occupancy counts are 0, the interrupt is low, and the receive threshold is 1 byte.
- R2: Only a write with reg_addr_i equal to 2 reaches the control register. Writes to any other offset change no output.
- R3: A control write with bit 0 set turns FIFO mode on. While it is on, each FIFO returns bytes in push order. A popped byte appears on the data output in the cycle after the pop, and the count shows each push and pop one cycle after its strobe. A control write with bit 0 set and bits 2:1 clear keeps the stored bytes.
- R4: A control write with bit 0 clear turns FIFO mode off and empties both FIFOs. The same write has no effect on the DMA mode, the threshold or the reset requests. While FIFO mode is off, pushes are dropped and both counts stay 0.
- R5: Bits 7:6 of an enabling write set the receive threshold: 00 selects 1 byte, 01 selects 4, 10 selects 8 and 11 selects 14. rx_irq_o is high exactly when FIFO mode is on and rx_count_o is at or above the threshold.
- R6: An enabling write with bit 1 set empties the receive FIFO and leaves the transmit FIFO unchanged. The request is not stored, so later pushes are accepted normally.
- R7: An enabling write with bit 2 set empties the transmit FIFO and leaves the receive FIFO unchanged. The request is not stored.
- R8: Bit 3 of an enabling write drives dma_mode_o (1 selects mode 1, 0 selects mode 0). Bits 5:4 have no effect.
- R9: Each FIFO holds 16 bytes. A push into a full FIFO is dropped, and the count never exceeds 16.
- R10: A pop from an empty FIFO leaves the data output and the count unchanged.
- R11: A flush in the same cycle as a push or pop on that FIFO wins, and the FIFO ends that cycle empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| tx_push_i | input | 1 | Transmit FIFO push strobe |
| tx_data_i | input | 8 | Transmit byte to push |
| tx_pop_i | input | 1 | Transmit FIFO pop strobe from the shifter |
| tx_data_o | output | 8 | Last byte popped from the transmit FIFO |
| tx_count_o | output | 5 | Transmit FIFO occupancy |
| rx_push_i | input | 1 | Receive FIFO push strobe from the shifter |
| rx_data_i | input | 8 | Received byte to push |
| rx_pop_i | input | 1 | Receive FIFO pop strobe |
| rx_data_o | output | 8 | Last byte popped from the receive FIFO |
| rx_count_o | output | 5 | Receive FIFO occupancy |
| fifo_en_o | output | 1 | FIFO mode on |
| dma_mode_o | output | 1 | DMA signalling mode select |
| rx_irq_o | output | 1 | Receive data available at threshold |

## Verification
The assertions check on every cycle that the occupancy never exceeds the depth and that the interrupt never rises while FIFO mode is off or the receive FIFO is empty. They also check that a disabling write empties both FIFOs and keeps the DMA mode, that each flush bit empties its own FIFO, that writes to other offsets change nothing, and that a pop from an empty FIFO holds the data output. Only the bench's scenarios can show the byte order through each FIFO, the exact threshold reached for each of the four codes, and the priority of a flush over a push or pop in the same cycle. The bench checks these against a queue model of both FIFOs and the register.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned DEPTH      = 16;
  localparam int unsigned ADDR_W     = 3;
  localparam int unsigned FCR_OFFSET = 2;
  localparam int unsigned CNT_W      = $clog2(DEPTH + 1);

  // Control byte field positions
  localparam int unsigned BIT_EN     = 0;
  localparam int unsigned BIT_RX_CLR = 1;
  localparam int unsigned BIT_TX_CLR = 2;
  localparam int unsigned BIT_DMA    = 3;
  localparam int unsigned BIT_TRIG   = 6;

  typedef enum logic [1:0] {
    TRIG_1  = 2'b00,
    TRIG_4  = 2'b01,
    TRIG_8  = 2'b10,
    TRIG_14 = 2'b11
  } trig_e;

  function automatic int unsigned trig_level(trig_e code);
    case (code)
      TRIG_1:  return 1;
      TRIG_4:  return 4;
      TRIG_8:  return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/fcr_reg.sv
module fcr_reg
  import uart_fifo_pkg::*;
#(
  parameter int unsigned ADDR_W_P  = ADDR_W,
  parameter int unsigned OFFSET_P  = FCR_OFFSET
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W_P-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic              en_o,
  output logic              dma_o,
  output trig_e             trig_o,
  output logic              rx_clr_o,
  output logic              tx_clr_o
);
  logic wr, on;
  logic en_q, dma_q;
  trig_e trig_q;

  assign wr = we_i && (addr_i == ADDR_W_P'(OFFSET_P));
  assign on = wdata_i[BIT_EN];

  // Flush pulses act in the write cycle and are never stored
  assign rx_clr_o = wr && (!on || wdata_i[BIT_RX_CLR]);
  assign tx_clr_o = wr && (!on || wdata_i[BIT_TX_CLR]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      dma_q  <= 1'b0;
      trig_q <= TRIG_1;
    end else if (wr) begin
      en_q <= on;
      if (on) begin
        dma_q  <= wdata_i[BIT_DMA];
        trig_q <= trig_e'(wdata_i[BIT_TRIG+1:BIT_TRIG]);
      end
    end
  end

  assign en_o   = en_q;
  assign dma_o  = dma_q;
  assign trig_o = trig_q;
endmodule

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] dout_o,
  output logic [CNT_W-1:0]  count_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wp_q, rp_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] dout_q;
  logic do_push, do_pop;

  assign do_pop  = en_i && pop_i  && (cnt_q != '0);
  assign do_push = en_i && push_i && (cnt_q != CNT_W'(DEPTH));

  function automatic logic [PTR_W-1:0] nxt(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
      dout_q <= '0;
    end else if (clr_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop) begin
        rp_q   <= nxt(rp_q);
        dout_q <= mem[rp_q];
      end
      cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem[wp_q] <= din_i;
  end

  assign dout_o  = dout_q;
  assign count_o = cnt_q;
endmodule

// File: rtl/rx_trigger.sv
module rx_trigger
  import uart_fifo_pkg::*;
#(
  parameter int unsigned CNT_W_P = CNT_W
) (
  input  logic               en_i,
  input  trig_e              trig_i,
  input  logic [CNT_W_P-1:0] count_i,
  output logic               irq_o
);
  logic [CNT_W_P-1:0] level;

  assign level = CNT_W_P'(trig_level(trig_i));
  assign irq_o = en_i && (count_i >= level);
endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import uart_fifo_pkg::*;
#(
  parameter int unsigned DATA_W_P   = DATA_W,
  parameter int unsigned DEPTH_P    = DEPTH,
  parameter int unsigned ADDR_W_P   = ADDR_W,
  parameter int unsigned OFFSET_P   = FCR_OFFSET,
  localparam int unsigned CNT_W_L   = $clog2(DEPTH_P + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [ADDR_W_P-1:0] reg_addr_i,
  input  logic [7:0]          reg_wdata_i,
  input  logic                tx_push_i,
  input  logic [DATA_W_P-1:0] tx_data_i,
  input  logic                tx_pop_i,
  output logic [DATA_W_P-1:0] tx_data_o,
  output logic [CNT_W_L-1:0]  tx_count_o,
  input  logic                rx_push_i,
  input  logic [DATA_W_P-1:0] rx_data_i,
  input  logic                rx_pop_i,
  output logic [DATA_W_P-1:0] rx_data_o,
  output logic [CNT_W_L-1:0]  rx_count_o,
  output logic                fifo_en_o,
  output logic                dma_mode_o,
  output logic                rx_irq_o
);
  logic  en, rx_clr, tx_clr;
  trig_e trig;

  fcr_reg #(.ADDR_W_P(ADDR_W_P), .OFFSET_P(OFFSET_P)) u_fcr (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .en_o(en), .dma_o(dma_mode_o), .trig_o(trig),
    .rx_clr_o(rx_clr), .tx_clr_o(tx_clr)
  );

  byte_fifo #(.DATA_W(DATA_W_P), .DEPTH(DEPTH_P)) u_tx_fifo (
    .clk_i, .rst_ni, .en_i(en), .clr_i(tx_clr),
    .push_i(tx_push_i), .din_i(tx_data_i), .pop_i(tx_pop_i),
    .dout_o(tx_data_o), .count_o(tx_count_o)
  );

  byte_fifo #(.DATA_W(DATA_W_P), .DEPTH(DEPTH_P)) u_rx_fifo (
    .clk_i, .rst_ni, .en_i(en), .clr_i(rx_clr),
    .push_i(rx_push_i), .din_i(rx_data_i), .pop_i(rx_pop_i),
    .dout_o(rx_data_o), .count_o(rx_count_o)
  );

  rx_trigger #(.CNT_W_P(CNT_W_L)) u_trig (
    .en_i(en), .trig_i(trig), .count_i(rx_count_o), .irq_o(rx_irq_o)
  );

  assign fifo_en_o = en;
endmodule

// File: rtl/uart_fifo_ctrl_chk.sv
module uart_fifo_ctrl_chk #(
  parameter int unsigned DATA_W_P = 8,
  parameter int unsigned DEPTH_P  = 16,
  parameter int unsigned ADDR_W_P = 3,
  parameter int unsigned OFFSET_P = 2,
  localparam int unsigned CNT_W_L = $clog2(DEPTH_P + 1)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                reg_we_i,
  input logic [ADDR_W_P-1:0] reg_addr_i,
  input logic [7:0]          reg_wdata_i,
  input logic                rx_pop_i,
  input logic [DATA_W_P-1:0] tx_data_o,
  input logic [CNT_W_L-1:0]  tx_count_o,
  input logic [DATA_W_P-1:0] rx_data_o,
  input logic [CNT_W_L-1:0]  rx_count_o,
  input logic                fifo_en_o,
  input logic                dma_mode_o,
  input logic                rx_irq_o
);
  logic wr;
  assign wr = reg_we_i && (reg_addr_i == ADDR_W_P'(OFFSET_P));

  assert_count_cap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_count_o <= CNT_W_L'(DEPTH_P)) && (tx_count_o <= CNT_W_L'(DEPTH_P)));

  assert_disable_flush_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && !reg_wdata_i[0]) |=> (!fifo_en_o && rx_count_o == '0 && tx_count_o == '0
                                  && dma_mode_o == $past(dma_mode_o)));

  assert_irq_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |-> (fifo_en_o && rx_count_o != '0));

  assert_rx_flush_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && reg_wdata_i[0] && reg_wdata_i[1]) |=> (rx_count_o == '0));

  assert_tx_flush_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && reg_wdata_i[0] && reg_wdata_i[2]) |=> (tx_count_o == '0));

  assert_dma_sel_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && reg_wdata_i[0]) |=> (dma_mode_o == $past(reg_wdata_i[3])));

  assert_other_offset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !wr) |=> ($stable(fifo_en_o) && $stable(dma_mode_o)));

  assert_pop_empty_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_pop_i && rx_count_o == '0) |=> $stable(rx_data_o));
endmodule

bind uart_fifo_ctrl uart_fifo_ctrl_chk #(
  .DATA_W_P(DATA_W_P), .DEPTH_P(DEPTH_P), .ADDR_W_P(ADDR_W_P), .OFFSET_P(OFFSET_P)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .rx_pop_i(rx_pop_i), .tx_data_o(tx_data_o),
  .tx_count_o(tx_count_o), .rx_data_o(rx_data_o), .rx_count_o(rx_count_o),
  .fifo_en_o(fifo_en_o), .dma_mode_o(dma_mode_o), .rx_irq_o(rx_irq_o)
);

// File: tb/tb_uart_fifo_ctrl.sv
`timescale 1ns/1ps
module tb_uart_fifo_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [2:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic       tx_push_i = 1'b0, tx_pop_i = 1'b0, rx_push_i = 1'b0, rx_pop_i = 1'b0;
  logic [7:0] tx_data_i = '0, rx_data_i = '0;
  logic [7:0] tx_data_o, rx_data_o;
  logic [4:0] tx_count_o, rx_count_o;
  logic       fifo_en_o, dma_mode_o, rx_irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  uart_fifo_ctrl dut (.*);

  // Reference model
  logic [7:0] rxq[$];
  logic [7:0] txq[$];
  logic [7:0] rx_out = '0, tx_out = '0;
  bit         en_m = 0, dma_m = 0;
  logic [1:0] trig_m = '0;

  function automatic int lvl(logic [1:0] c);
    case (c)
      2'b00: return 1;
      2'b01: return 4;
      2'b10: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FIFO-CHK FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic chk_all();
    chk("R3 rx_count", rx_count_o, rxq.size());
    chk("R3 tx_count", tx_count_o, txq.size());
    chk("R3 rx_data", rx_data_o, rx_out);
    chk("R3 tx_data", tx_data_o, tx_out);
    chk("R4 fifo_en", fifo_en_o, en_m);
    chk("R8 dma_mode", dma_mode_o, dma_m);
    chk("R5 rx_irq", rx_irq_o, (en_m && rxq.size() >= lvl(trig_m)) ? 1 : 0);
  endtask

  task automatic model_step(bit we, logic [2:0] a, logic [7:0] d,
                            bit tp, logic [7:0] td, bit tq,
                            bit rp, logic [7:0] rd, bit rq);
    bit wr = we && (a == 3'd2);
    int n;
    if (wr && !d[0]) begin
      en_m = 0;
      rxq.delete();
      txq.delete();
    end else begin
      if (wr && d[1]) rxq.delete();
      else if (en_m) begin
        n = rxq.size();
        if (rq && n > 0) rx_out = rxq.pop_front();
        if (rp && n < 16) rxq.push_back(rd);
      end
      if (wr && d[2]) txq.delete();
      else if (en_m) begin
        n = txq.size();
        if (tq && n > 0) tx_out = txq.pop_front();
        if (tp && n < 16) txq.push_back(td);
      end
      if (wr) begin
        en_m = 1;
        dma_m = d[3];
        trig_m = d[7:6];
      end
    end
  endtask

  // One cycle: drive at negedge, model after the edge, compare, release at next negedge
  task automatic cyc(bit we, logic [2:0] a, logic [7:0] d,
                     bit tp, logic [7:0] td, bit tq,
                     bit rp, logic [7:0] rd, bit rq);
    reg_we_i = we; reg_addr_i = a; reg_wdata_i = d;
    tx_push_i = tp; tx_data_i = td; tx_pop_i = tq;
    rx_push_i = rp; rx_data_i = rd; rx_pop_i = rq;
    @(posedge clk_i);
    #1;
    model_step(we, a, d, tp, td, tq, rp, rd, rq);
    chk_all();
    @(negedge clk_i);
    reg_we_i = 0; tx_push_i = 0; tx_pop_i = 0; rx_push_i = 0; rx_pop_i = 0;
  endtask

  task automatic wreg(logic [2:0] a, logic [7:0] d);
    cyc(1, a, d, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic rx_push(logic [7:0] v); cyc(0, 0, 0, 0, 0, 0, 1, v, 0); endtask
  task automatic rx_pop();               cyc(0, 0, 0, 0, 0, 0, 0, 0, 1); endtask
  task automatic tx_push(logic [7:0] v); cyc(0, 0, 0, 1, v, 0, 0, 0, 0); endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FIFO-CHK FAIL watchdog: got 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    // R1 reset state
    chk("R1 fifo_en", fifo_en_o, 0);
    chk("R1 dma_mode", dma_mode_o, 0);
    chk("R1 rx_count", rx_count_o, 0);
    chk("R1 tx_count", tx_count_o, 0);
    chk("R1 rx_irq", rx_irq_o, 0);
    @(negedge clk_i);

    // R4 push while disabled is dropped
    rx_push(8'h11);
    chk("R4 disabled push", rx_count_o, 0);

    // R3 enable, threshold 1 (R1 default code), ordering
    wreg(3'd2, 8'h01);
    chk("R1 threshold 1 irq low at 0", rx_irq_o, 0);
    rx_push(8'hA5);
    chk("R1 threshold 1 irq", rx_irq_o, 1);
    rx_push(8'h3C);
    rx_pop();
    chk("R3 first out", rx_data_o, 8'hA5);
    rx_pop();
    chk("R3 second out", rx_data_o, 8'h3C);

    // R10 pop on empty
    rx_pop();
    chk("R10 empty pop data", rx_data_o, 8'h3C);
    chk("R10 empty pop count", rx_count_o, 0);

    // R9 fill past depth
    for (int i = 0; i < 20; i++) rx_push(8'(i + 8'h40));
    chk("R9 full count", rx_count_o, 16);
    for (int i = 0; i < 16; i++) rx_pop();
    chk("R9 last kept", rx_data_o, 8'h4F);

    // R5 thresholds
    for (int c = 0; c < 4; c++) begin
      wreg(3'd2, 8'(c << 6) | 8'h03);
      for (int k = 0; k < 15; k++) begin
        chk($sformatf("R5 code %0d count %0d", c, rx_count_o), rx_irq_o,
            (k >= lvl(2'(c))) ? 1 : 0);
        rx_push(8'(k));
      end
    end

    // R2 other offset ignored (would disable and flush at offset 2)
    wreg(3'd3, 8'h00);
    chk("R2 other offset en", fifo_en_o, 1);
    chk("R2 other offset count", rx_count_o, 15);

    // R6 / R7 selective flush, no stored request
    tx_push(8'h77); tx_push(8'h78);
    wreg(3'd2, 8'h03);
    chk("R6 rx flushed", rx_count_o, 0);
    chk("R6 tx kept", tx_count_o, 2);
    rx_push(8'h99);
    chk("R6 not sticky", rx_count_o, 1);
    wreg(3'd2, 8'h05);
    chk("R7 tx flushed", tx_count_o, 0);
    chk("R7 rx kept", rx_count_o, 1);
    tx_push(8'h12);
    chk("R7 not sticky", tx_count_o, 1);

    // R8 dma select, reserved bits ignored
    wreg(3'd2, 8'h39);
    chk("R8 dma set", dma_mode_o, 1);
    chk("R8 reserved no flush", rx_count_o, 1);
    wreg(3'd2, 8'h31);
    chk("R8 dma clear", dma_mode_o, 0);

    // R11 flush wins over push/pop same cycle
    rx_push(8'h01); rx_push(8'h02);
    cyc(1, 3'd2, 8'h07, 1, 8'hEE, 1, 1, 8'hDD, 1);
    chk("R11 rx empty", rx_count_o, 0);
    chk("R11 tx empty", tx_count_o, 0);

    // R4 disable flushes, ignores dma bit
    wreg(3'd2, 8'h09);
    rx_push(8'h5A); tx_push(8'h5B);
    wreg(3'd2, 8'h00);
    chk("R4 en off", fifo_en_o, 0);
    chk("R4 dma kept", dma_mode_o, 1);
    chk("R4 rx flushed", rx_count_o, 0);
    chk("R4 tx flushed", tx_count_o, 0);
    chk("R4 irq low", rx_irq_o, 0);

    // Constrained random
    for (int n = 0; n < 4000; n++) begin
      bit we = ($urandom_range(0, 19) == 0);
      logic [2:0] a = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'd2;
      logic [7:0] d = 8'($urandom);
      if ($urandom_range(0, 7) != 0) d[0] = 1'b1;
      if ($urandom_range(0, 3) != 0) d[2:1] = 2'b00;
      cyc(we, a, d,
          ($urandom_range(0, 2) == 0), 8'($urandom), ($urandom_range(0, 3) == 0),
          ($urandom_range(0, 2) == 0), 8'($urandom), ($urandom_range(0, 3) == 0));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule